// File: doc/BRIEF.md
# Half-Duplex Single-Wire Synchronous Serial PHY

This block is the bit-level layer of a half-duplex link that runs over one shared data wire, clocked by a bit clock that the external host supplies. When idle it listens on the wire. It detects a start bit, shifts in a 12-bit character and hands the byte to an upper access layer with a one-cycle strobe. Three exception flags travel with that byte: a bad stop bit, a parity mismatch and a break.

When the access layer selects transmit mode, the block accepts a byte through a ready/load handshake. It drives the character onto the wire through a separate output enable for the pad's tristate driver. An optional number of idle-high bits can precede the start bit. While it drives the wire, the block reads the wire back on every bit. If the wire shows a value other than the one driven, the block drops the driver and abandons the character.

Any exception puts the block into a recovery state. In that state it accepts no ordinary character and no transmit request until an all-zero break character arrives.

Top module: `hdx_phy`

## Requirements
- R1: After reset the wire is released (`line_oe`=0, `line_out`=1), `rx_valid` and `tx_coll` are low, and `tx_ready` is low while `tx_mode` is low.
- R2: A character is 12 bit times long: a start bit of 0, then 8 data bits with the least significant bit first, then an even parity bit (equal to the XOR of the data bits), then two stop bits of 1. The receiver samples `line_in` on rising clock edges. `rx_valid` rises on the rising edge that samples the second stop bit, and at no earlier edge.
- R3: `rx_valid` is high for exactly one clock per received character, with `rx_data` holding the received byte.
- R4: `rx_ferr` is set when either stop bit is sampled as 0.
- R5: `rx_perr` is set when the received parity bit differs from the XOR of the received data bits.
- R6: A character whose 12 bits are all 0 is reported as a break: `rx_brk`=1, `rx_ferr`=1, `rx_perr`=0, `rx_data`=0. It ends the recovery state.
- R7: After a frame error, a parity error or a collision, characters that are not a break produce no `rx_valid`, and `tx_ready` stays low, until a break has been received.
- R8: `tx_ready` is high only when `tx_mode` is high, no character is being sent or received, and the block is not in recovery. On a rising edge with `tx_load` and `tx_ready` both high, the block latches `tx_data` and `tx_gap` and sends one character, one bit per clock, with `line_out` changing only on falling edges.
- R9: `line_oe` rises on the falling edge after the load and falls on the falling edge after the rising edge on which the last stop bit is read back. While `line_oe` is low, `line_out` is 1.
- R10: When `tx_gap`=N, N bit times of 1 are driven before the start bit, with the driver enabled for all of them.
- R11: If `line_in` differs from `line_out` on a rising edge while the block is driving, `tx_coll` pulses for one clock and the driver is released on the next falling edge. The rest of the character is dropped and the block enters the recovery state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock from the external host |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Value read from the data wire |
| line_out | output | 1 | Value to drive on the data wire |
| line_oe | output | 1 | Enable for the wire's tristate driver |
| tx_mode | input | 1 | Access layer selects transmit (1) or receive (0) |
| tx_data | input | 8 | Byte to send |
| tx_gap | input | 2 | Number of idle-high bits to send before the start bit |
| tx_load | input | 1 | Start sending `tx_data` (taken when `tx_ready` is high) |
| tx_ready | output | 1 | Transmitter can accept a byte |
| tx_coll | output | 1 | One-cycle pulse when a collision aborts a character |
| rx_valid | output | 1 | One-cycle strobe: received byte and flags are valid |
| rx_data | output | 8 | Received byte |
| rx_ferr | output | 1 | Stop-bit error on the reported character |
| rx_perr | output | 1 | Parity error on the reported character |
| rx_brk | output | 1 | Reported character was a break |

## Verification
A bit counter that slips by one position shows within a single character. The strobe arrives a clock early or late, the received byte comes out shifted, and the parity flag goes wrong on the same strobe. A transmit counter fault shows as a missing or extra bit read back at the wire, or as the enable still high one falling edge after the last stop bit. A recovery flag that clears too early, or never clears, is hidden during normal traffic. It shows only on the next character after an error: a strobe appears where none should, `tx_ready` returns before a break, or nothing is accepted after a break. The bench therefore always follows an error with ordinary traffic, then a break, then ordinary traffic again.

// File: rtl/hdx_phy.sv
module hdx_phy #(
  parameter int DATA_W = 8,
  parameter int GAP_W  = 2
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              line_in,
  output logic              line_out,
  output logic              line_oe,
  input  logic              tx_mode,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [GAP_W-1:0]  tx_gap,
  input  logic              tx_load,
  output logic              tx_ready,
  output logic              tx_coll,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ferr,
  output logic              rx_perr,
  output logic              rx_brk
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic                 rx_busy, hold, tx_act;
  logic [CNT_W-1:0]     rx_cnt, tx_left;
  logic [FRAME_W-2:0]   rx_sh;
  logic [FRAME_W-1:0]   tx_sh;
  logic [GAP_W-1:0]     gap_cnt;

  wire [FRAME_W-2:0] rx_nxt = {line_in, rx_sh[FRAME_W-2:1]};
  wire [DATA_W-1:0]  f_data = rx_nxt[DATA_W-1:0];
  wire f_brk = (rx_nxt == '0);
  wire f_fe  = (rx_nxt[DATA_W+2:DATA_W+1] != 2'b11);
  wire f_pe  = (rx_nxt[DATA_W] != ^f_data);
  wire rx_en = !tx_mode && !tx_act;
  wire clash = line_oe && (line_in != line_out);

  assign tx_ready = tx_mode && !tx_act && !rx_busy && !hold;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy  <= 1'b0;
      rx_cnt   <= '0;
      rx_sh    <= '0;
      hold     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_ferr  <= 1'b0;
      rx_perr  <= 1'b0;
      rx_brk   <= 1'b0;
      tx_act   <= 1'b0;
      tx_sh    <= '1;
      tx_left  <= '0;
      gap_cnt  <= '0;
      tx_coll  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_coll  <= 1'b0;
      if (!rx_busy) begin
        if (rx_en && !line_in) begin
          rx_busy <= 1'b1;
          rx_cnt  <= '0;
        end
      end else begin
        rx_sh  <= rx_nxt;
        rx_cnt <= rx_cnt + 1'b1;
        if (rx_cnt == CNT_W'(FRAME_W - 2)) begin
          rx_busy <= 1'b0;
          if (!hold || f_brk) begin
            rx_valid <= 1'b1;
            rx_data  <= f_data;
            rx_ferr  <= f_fe;
            rx_perr  <= f_pe;
            rx_brk   <= f_brk;
            hold     <= (f_fe || f_pe) && !f_brk;
          end
        end
      end
      if (tx_act) begin
        if (clash) begin
          tx_act  <= 1'b0;
          tx_coll <= 1'b1;
          hold    <= 1'b1;
        end else if (gap_cnt != '0) begin
          gap_cnt <= gap_cnt - 1'b1;
        end else begin
          tx_sh   <= {1'b1, tx_sh[FRAME_W-1:1]};
          tx_left <= tx_left - 1'b1;
          if (tx_left == CNT_W'(1)) tx_act <= 1'b0;
        end
      end else if (tx_load && tx_ready) begin
        tx_act  <= 1'b1;
        tx_sh   <= {2'b11, ^tx_data, tx_data, 1'b0};
        tx_left <= CNT_W'(FRAME_W);
        gap_cnt <= tx_gap;
      end
    end
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      line_oe  <= 1'b0;
      line_out <= 1'b1;
    end else begin
      line_oe  <= tx_act;
      line_out <= !tx_act || gap_cnt != '0 || tx_sh[0];
    end
  end

  AST_RX_PULSE: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);                                              // R3
  AST_BRK_FLAGS: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid && rx_brk |-> rx_ferr && !rx_perr && rx_data == '0);         // R6
  AST_COLL_RELEASE: assert property (@(posedge bclk) disable iff (!rst_n)
    tx_coll |-> !line_oe && !tx_ready);                                   // R11
  AST_READY_MODE: assert property (@(posedge bclk) disable iff (!rst_n)
    tx_ready |-> tx_mode && !line_oe);                                    // R8
  AST_IDLE_HIGH: assert property (@(posedge bclk) disable iff (!rst_n)
    !line_oe |-> line_out);                                               // R9
endmodule

// File: tb/sim_hdx_phy.sv
module sim_hdx_phy;
  localparam int CLK_P = 10;

  logic bclk = 0, rst_n = 0;
  logic host_bit = 1, flip = 0;
  logic tx_mode = 0, tx_load = 0;
  logic [7:0] tx_data = 0;
  logic [1:0] tx_gap = 0;
  logic line_out, line_oe, tx_ready, tx_coll;
  logic rx_valid, rx_ferr, rx_perr, rx_brk;
  logic [7:0] rx_data;
  wire line_in = line_oe ? (line_out ^ flip) : host_bit;

  int checks = 0, fails = 0, vcount = 0;

  hdx_phy u0 (.bclk(bclk), .rst_n(rst_n), .line_in(line_in), .line_out(line_out),
    .line_oe(line_oe), .tx_mode(tx_mode), .tx_data(tx_data), .tx_gap(tx_gap),
    .tx_load(tx_load), .tx_ready(tx_ready), .tx_coll(tx_coll), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_brk(rx_brk));

  always #(CLK_P/2) bclk = ~bclk;
  always @(negedge bclk) if (rx_valid) vcount++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic [11:0] mk(input [7:0] d, input bit bad_par, input bit stop2);
    return {stop2, 1'b1, (^d) ^ bad_par, d, 1'b0};
  endfunction

  // host drives 12 bits; outputs are captured half a cycle after the last sampling edge
  task automatic host_frame(input [11:0] bits, output bit v, output bit [7:0] d,
                            output bit fe, output bit pe, output bit bk, output bit early);
    early = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge bclk);
      if (rx_valid) early = 1;
      host_bit = bits[i];
    end
    @(negedge bclk);
    v = rx_valid; d = rx_data; fe = rx_ferr; pe = rx_perr; bk = rx_brk;
    host_bit = 1;
    @(negedge bclk);
  endtask

  task automatic t_reset;
    #1;
    chk(!line_oe && line_out, "R1 wire released", {line_oe, line_out}, 2'b01);
    chk(!rx_valid && !tx_coll, "R1 no strobes", {rx_valid, tx_coll}, 0);
    chk(!tx_ready, "R1 tx_ready low in rx mode", tx_ready, 0);
  endtask

  task automatic t_rx_good(input [7:0] b);
    bit v, fe, pe, bk, early; bit [7:0] d; int c0;
    host_frame(mk(b, 0, 1), v, d, fe, pe, bk, early);
    chk(!early, "R2 no strobe before second stop bit", early, 0);
    chk(v && d == b, "R2 byte received LSB first", {v, d}, {1'b1, b});
    chk(!fe && !pe && !bk, "R4 R5 clean flags", {fe, pe, bk}, 0);
    c0 = vcount;
    @(negedge bclk);
    chk(!rx_valid && vcount == c0, "R3 strobe lasts one clock", rx_valid, 0);
  endtask

  task automatic t_break(input string req);
    bit v, fe, pe, bk, early; bit [7:0] d;
    host_frame(12'h000, v, d, fe, pe, bk, early);
    chk(v && bk && fe && !pe && d == 0, {req, " break reported"},
        {v, bk, fe, pe, d}, {3'b111, 1'b0, 8'h00});
  endtask

  task automatic t_ignored(input string req);
    bit v, fe, pe, bk, early; bit [7:0] d; int c0;
    c0 = vcount;
    host_frame(mk(8'h5A, 0, 1), v, d, fe, pe, bk, early);
    chk(vcount == c0, {req, " frame ignored while waiting for break"}, vcount - c0, 0);
  endtask

  task automatic t_parity;
    bit v, fe, pe, bk, early; bit [7:0] d;
    host_frame(mk(8'h37, 1, 1), v, d, fe, pe, bk, early);
    chk(v && pe && !fe && !bk && d == 8'h37, "R5 parity error", {v, pe, fe, bk}, 4'b1100);
    t_ignored("R7");
    tx_mode = 1; #1;
    chk(!tx_ready, "R7 no tx before break", tx_ready, 0);
    tx_mode = 0;
    t_break("R6");
    t_rx_good(8'hC3);
  endtask

  task automatic t_frame_err;
    bit v, fe, pe, bk, early; bit [7:0] d;
    host_frame(mk(8'h81, 0, 0), v, d, fe, pe, bk, early);
    chk(v && fe && !pe && !bk && d == 8'h81, "R4 stop bit error", {v, fe, pe, bk}, 4'b1100);
    t_ignored("R7");
    t_break("R6");
  endtask

  task automatic t_tx(input [7:0] b, input [1:0] gap);
    bit [11:0] exp; int n; bit ok; bit pre;
    exp = {2'b11, ^b, b, 1'b0};
    n = 12 + gap;
    tx_mode = 1;
    @(negedge bclk); #1;
    chk(tx_ready, "R8 tx_ready in tx mode", tx_ready, 1);
    tx_data = b; tx_gap = gap; tx_load = 1;
    @(negedge bclk); tx_load = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge bclk); #1;
      pre = line_out;
      chk(line_oe, "R9 driver enabled during frame", line_oe, 1);
      ok = (i < gap) ? line_out : (line_out == exp[i - gap]);
      chk(ok, (i < gap) ? "R10 gap bit high" : "R8 transmitted bit",
          line_out, (i < gap) ? 1 : exp[i - gap]);
      @(negedge bclk); #1;
      if (i == n - 1) chk(!line_oe && line_out, "R9 driver released after last stop", line_oe, 0);
      else if (i >= gap && exp[i - gap] == exp[i - gap + 1])
        chk(line_out == pre, "R8 bit held until falling edge", line_out, pre);
    end
    tx_mode = 0;
    @(negedge bclk);
  endtask

  task automatic t_collision;
    tx_mode = 1;
    @(negedge bclk);
    tx_data = 8'hFF; tx_gap = 0; tx_load = 1;
    @(negedge bclk); tx_load = 0;
    @(negedge bclk); @(negedge bclk);
    #1 flip = 1;
    @(posedge bclk); #1;
    flip = 0;
    chk(tx_coll, "R11 collision pulse", tx_coll, 1);
    @(negedge bclk); #1;
    chk(!line_oe && line_out, "R11 driver released", {line_oe, line_out}, 2'b01);
    chk(!tx_ready, "R11 tx blocked after collision", tx_ready, 0);
    @(posedge bclk); #1;
    chk(!tx_coll, "R11 pulse one clock", tx_coll, 0);
    tx_mode = 0;
    @(negedge bclk);
    t_ignored("R11");
    t_break("R7");
    tx_mode = 1; #1;
    chk(tx_ready, "R7 tx resumes after break", tx_ready, 1);
    tx_mode = 0;
    @(negedge bclk);
  endtask

  initial begin
    repeat (3) @(negedge bclk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge bclk);
    t_rx_good(8'hA5);
    t_rx_good(8'h00);
    t_rx_good(8'hFF);
    t_parity();
    t_frame_err();
    t_tx(8'h3C, 0);
    t_tx(8'h01, 2);
    t_collision();
    t_rx_good(8'h6E);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge bclk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule